// File: doc/BRIEF.md
# Set-Associative Byte Data Cache

This block is a small data cache that sits between a processor-side byte port and a block-wide memory port. Its geometry is fixed when it is built: the number of sets, the number of ways in each set and the bytes in each block are all powers of two that come from parameters. Each access is a single byte read or a single byte write. When the access completes, the cache reports whether it hit or missed. Misses are served by fetching whole blocks over the memory port and, where the policy calls for it, by writing a whole victim block back.

A build-time switch chooses one of two write policies. Write-back mode uses write-allocate and keeps a dirty flag on every line. Write-through mode uses no-write-allocate and sends every write to memory at once. Only one request is handled at a time, so the processor port stays busy until all of the memory traffic for the request has finished. Two running counters record completed hits and completed misses.

Top module: `sa_data_cache`

## Requirements
- R1: A byte address is split into three fields. The lowest OFF_BITS bits are the byte offset within the block. The next SET_BITS bits select the set. All remaining upper bits form the tag.
- R2: A read hits when some way in the selected set is valid and its stored tag equals the address tag. It then returns the byte at the block offset, and at most one way can match.
- R3: Direct mapped, with 4-bit addresses, 2-byte blocks and 4 sets: the reads 0, 1, 7, 8, 0 give miss, hit, miss, miss, miss.
- R4: Two ways, with 4-bit addresses, 2-byte blocks and 2 sets: the reads 0, 1, 7, 8, 0 give miss, hit, miss, miss, hit.
- R5: On a miss, the lowest-numbered invalid way of the set is filled first. When no way is invalid, the least recently used way is replaced. Both hits and fills count as uses. After reset, way 0 is the first victim.
- R6: In write-back mode, a write hit changes only the cached copy and marks the line dirty. A dirty victim is written to memory as a whole block before the new block is fetched.
- R7: In write-back mode, a write miss first fetches the block into the cache and then updates it, so a following read of that byte hits.
- R8: In write-through mode, a write hit updates the cached byte and also writes that byte to memory before the access completes.
- R9: In write-through mode, a write miss writes the byte to memory only and allocates no line, so a following read of that byte misses. This mode never writes a whole block to memory.
- R10: Every completed access raises exactly one of hitCount or missCount by one. An access that needed a fill counts as a miss.
- R11: After reset the cache is cold, reqReady is 1, rspValid is 0 and both counters are 0.
- R12: From the moment a request is accepted until its response, reqReady stays 0. On a miss this covers the fill and any writeback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Processor request present; accepted when reqReady is 1 |
| reqWrite | input | 1 | 1 = byte write, 0 = byte read |
| reqAddr | input | ADDR_W | Byte address |
| reqWdata | input | 8 | Write byte |
| reqReady | output | 1 | Cache idle and able to accept a request |
| rspValid | output | 1 | One-cycle pulse when the access completes |
| rspHit | output | 1 | Outcome of the completing access (1 = hit) |
| rspRdata | output | 8 | Read byte, valid with rspValid on a read |
| memReqValid | output | 1 | One-cycle pulse starting a memory transaction |
| memReqWrite | output | 1 | 1 = write to memory, 0 = block fetch |
| memReqByte | output | 1 | 1 = single-byte write of memReqWdata[7:0] at memReqAddr |
| memReqAddr | output | ADDR_W | Block-aligned address, or the byte address for a single-byte write |
| memReqWdata | output | 8<<OFF_BITS | Victim block, or the write byte in the low bits |
| memRspValid | input | 1 | One-cycle completion pulse for the pending memory transaction |
| memRspData | input | 8<<OFF_BITS | Fetched block; byte k sits at bits 8k+7:8k |
| hitCount | output | CNT_W | Completed hits |
| missCount | output | CNT_W | Completed misses |

## Verification
The same five-read trace is run on a direct-mapped, write-through build and on a two-way, write-back build. The two builds give different outcomes on the final read, and that difference separates conflict eviction from associativity. On the two-way build, a write hit, a clean eviction, a dirty eviction and a re-read are arranged so that a victim chosen by least recent use gives a different hit/miss sequence and different memory contents than any other victim choice. Write misses followed by reads of the same byte tell allocate apart from no-allocate. The memory contents are checked right after each write to tell a deferred write from an immediate one.

// File: rtl/cache_pkg.sv
package cache_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMP,
    ST_WB_WAIT,
    ST_FILL_WAIT,
    ST_WT_WAIT
  } cacheState_t;

  typedef struct packed {
    logic latchReq;
    logic latchVictim;
    logic writeByte;
    logic touch;
    logic install;
    logic selVictim;
    logic selByte;
    logic countHit;
    logic countMiss;
  } ctlStrobe_t;

endpackage

// File: rtl/cache_datapath.sv
module cache_datapath
  import cache_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int SET_BITS   = 2,
  parameter int WAYS       = 2,
  parameter int OFF_BITS   = 1,
  parameter bit WRITE_BACK = 1'b1,
  parameter int CNT_W      = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  ctlStrobe_t               stb,
  input  logic [ADDR_W-1:0]        reqAddr,
  input  logic                     reqWrite,
  input  logic [7:0]               reqWdata,
  input  logic [(8<<OFF_BITS)-1:0] memRspData,
  output logic                     hitAny,
  output logic                     vicNeedsWb,
  output logic                     reqIsWrite,
  output logic [7:0]               rdData,
  output logic [ADDR_W-1:0]        memAddr,
  output logic [(8<<OFF_BITS)-1:0] memWdata,
  output logic [CNT_W-1:0]         hitCount,
  output logic [CNT_W-1:0]         missCount
);
  localparam int SETS   = 1 << SET_BITS;
  localparam int LINE_W = 8 << OFF_BITS;
  localparam int TAG_W  = ADDR_W - SET_BITS - OFF_BITS;
  localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1;

  logic [TAG_W-1:0]  tagMem  [SETS][WAYS];
  logic [LINE_W-1:0] dataMem [SETS][WAYS];
  logic [WAY_W-1:0]  ageMem  [SETS][WAYS];
  logic [WAYS-1:0]   validMem[SETS];
  logic [WAYS-1:0]   dirtyMem[SETS];

  logic [ADDR_W-1:0] reqAddrQ;
  logic [7:0]        reqWdataQ;
  logic              reqWriteQ;
  logic [WAY_W-1:0]  victimQ;

  logic [TAG_W-1:0]    reqTag;
  logic [SET_BITS-1:0] reqSet;
  logic [OFF_BITS-1:0] reqOff;
  logic [WAYS-1:0]     wayHit;
  logic [WAY_W-1:0]    hitWay;
  logic [WAY_W-1:0]    vicWay;
  logic                freeFound;

  assign reqTag     = reqAddrQ[ADDR_W-1 -: TAG_W];
  assign reqSet     = reqAddrQ[OFF_BITS +: SET_BITS];
  assign reqOff     = reqAddrQ[OFF_BITS-1:0];
  assign reqIsWrite = reqWriteQ;

  // tag compare, one comparator per way
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign wayHit[w] = validMem[reqSet][w] && (tagMem[reqSet][w] == reqTag);
  end
  assign hitAny = |wayHit;

  always_comb begin
    hitWay = '0;
    for (int w = 0; w < WAYS; w++)
      if (wayHit[w]) hitWay = WAY_W'(w);
  end

  // victim: lowest invalid way, else the oldest
  always_comb begin
    vicWay    = '0;
    freeFound = 1'b0;
    for (int w = 0; w < WAYS; w++) begin
      if (!validMem[reqSet][w] && !freeFound) begin
        vicWay    = WAY_W'(w);
        freeFound = 1'b1;
      end
    end
    if (!freeFound) begin
      for (int w = 0; w < WAYS; w++)
        if (ageMem[reqSet][w] == WAY_W'(WAYS - 1)) vicWay = WAY_W'(w);
    end
  end

  assign vicNeedsWb = WRITE_BACK && validMem[reqSet][vicWay] && dirtyMem[reqSet][vicWay];

  assign rdData = dataMem[reqSet][hitWay][{reqOff, 3'b000} +: 8];

  always_comb begin
    if (stb.selVictim)
      memAddr = {tagMem[reqSet][victimQ], reqSet, {OFF_BITS{1'b0}}};
    else if (stb.selByte)
      memAddr = reqAddrQ;
    else
      memAddr = {reqTag, reqSet, {OFF_BITS{1'b0}}};
    memWdata = stb.selByte ? LINE_W'(reqWdataQ) : dataMem[reqSet][victimQ];
  end

  // request capture and victim latch
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqAddrQ  <= '0;
      reqWdataQ <= '0;
      reqWriteQ <= 1'b0;
      victimQ   <= '0;
    end else begin
      if (stb.latchReq) begin
        reqAddrQ  <= reqAddr;
        reqWdataQ <= reqWdata;
        reqWriteQ <= reqWrite;
      end
      if (stb.latchVictim) victimQ <= vicWay;
    end
  end

  // line state: valid, dirty, recency
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++) begin
        validMem[s] <= '0;
        dirtyMem[s] <= '0;
        for (int w = 0; w < WAYS; w++) ageMem[s][w] <= WAY_W'(WAYS - 1 - w);
      end
    end else begin
      if (stb.install) begin
        validMem[reqSet][victimQ] <= 1'b1;
        dirtyMem[reqSet][victimQ] <= 1'b0;
      end
      if (stb.writeByte && WRITE_BACK) dirtyMem[reqSet][hitWay] <= 1'b1;
      if (stb.touch) begin
        for (int w = 0; w < WAYS; w++)
          if (ageMem[reqSet][w] < ageMem[reqSet][hitWay])
            ageMem[reqSet][w] <= ageMem[reqSet][w] + 1'b1;
        ageMem[reqSet][hitWay] <= '0;
      end
    end
  end

  // tag and data storage, no reset needed
  always_ff @(posedge clk) begin
    if (stb.install) begin
      tagMem[reqSet][victimQ]  <= reqTag;
      dataMem[reqSet][victimQ] <= memRspData;
    end
    if (stb.writeByte) dataMem[reqSet][hitWay][{reqOff, 3'b000} +: 8] <= reqWdataQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hitCount  <= '0;
      missCount <= '0;
    end else begin
      if (stb.countHit)  hitCount  <= hitCount + 1'b1;
      if (stb.countMiss) missCount <= missCount + 1'b1;
    end
  end

  // R2
  onehot_hit_chk: assert property (@(posedge clk) disable iff (!rstN) $onehot0(wayHit));

  // R5
  fill_then_hit_chk: assert property (@(posedge clk) disable iff (!rstN) stb.install |=> hitAny);

  // R10
  one_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.countHit || stb.countMiss) |=>
      ({1'b0, hitCount} + {1'b0, missCount}) ==
      ({1'b0, $past(hitCount)} + {1'b0, $past(missCount)} + 1'b1));

endmodule

// File: rtl/cache_control.sv
module cache_control
  import cache_pkg::*;
#(
  parameter bit WRITE_BACK = 1'b1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       hitAny,
  input  logic       vicNeedsWb,
  input  logic       reqIsWrite,
  input  logic       memRspValid,
  output ctlStrobe_t stb,
  output logic       reqReady,
  output logic       rspValid,
  output logic       rspHit,
  output logic       memReqValid,
  output logic       memReqWrite,
  output logic       memReqByte
);
  cacheState_t state, stateNext;
  logic missFlag, setMiss, issue;

  always_comb begin
    stb       = '0;
    stateNext = state;
    rspValid  = 1'b0;
    setMiss   = 1'b0;
    issue     = 1'b0;
    unique case (state)
      ST_IDLE: if (reqValid) begin
        stb.latchReq = 1'b1;
        stateNext    = ST_CMP;
      end
      ST_CMP: begin
        if (hitAny) begin
          stb.touch     = 1'b1;
          stb.writeByte = reqIsWrite;
          if (reqIsWrite && !WRITE_BACK) begin
            issue     = 1'b1;
            stateNext = ST_WT_WAIT;
          end else begin
            rspValid  = 1'b1;
            stateNext = ST_IDLE;
          end
        end else if (reqIsWrite && !WRITE_BACK) begin
          setMiss   = 1'b1;
          issue     = 1'b1;
          stateNext = ST_WT_WAIT;
        end else begin
          setMiss         = 1'b1;
          issue           = 1'b1;
          stb.latchVictim = 1'b1;
          stateNext       = vicNeedsWb ? ST_WB_WAIT : ST_FILL_WAIT;
        end
      end
      ST_WB_WAIT: if (memRspValid) begin
        issue     = 1'b1;
        stateNext = ST_FILL_WAIT;
      end
      ST_FILL_WAIT: if (memRspValid) begin
        stb.install = 1'b1;
        stateNext   = ST_CMP;
      end
      ST_WT_WAIT: if (memRspValid) begin
        rspValid  = 1'b1;
        stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
    stb.selVictim = (state == ST_WB_WAIT);
    stb.selByte   = (state == ST_WT_WAIT);
    stb.countHit  = rspValid && !missFlag;
    stb.countMiss = rspValid && missFlag;
  end

  assign reqReady    = (state == ST_IDLE);
  assign rspHit      = !missFlag;
  assign memReqWrite = (state == ST_WB_WAIT) || (state == ST_WT_WAIT);
  assign memReqByte  = (state == ST_WT_WAIT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      missFlag    <= 1'b0;
      memReqValid <= 1'b0;
    end else begin
      state       <= stateNext;
      memReqValid <= issue;
      if (stb.latchReq) missFlag <= 1'b0;
      else if (setMiss) missFlag <= 1'b1;
    end
  end

  // R12
  busy_while_mem_chk: assert property (@(posedge clk) disable iff (!rstN) memReqValid |-> !reqReady);

  if (WRITE_BACK) begin : g_wb_chk
    // R6
    wb_block_only_chk: assert property (@(posedge clk) disable iff (!rstN) memReqValid |-> !memReqByte);
  end else begin : g_wt_chk
    // R9
    wt_byte_only_chk: assert property (@(posedge clk) disable iff (!rstN)
      (memReqValid && memReqWrite) |-> memReqByte);
  end

endmodule

// File: rtl/sa_data_cache.sv
module sa_data_cache
  import cache_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int SET_BITS   = 2,
  parameter int WAYS       = 2,
  parameter int OFF_BITS   = 1,
  parameter bit WRITE_BACK = 1'b1,
  parameter int CNT_W      = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     reqValid,
  input  logic                     reqWrite,
  input  logic [ADDR_W-1:0]        reqAddr,
  input  logic [7:0]               reqWdata,
  output logic                     reqReady,
  output logic                     rspValid,
  output logic                     rspHit,
  output logic [7:0]               rspRdata,
  output logic                     memReqValid,
  output logic                     memReqWrite,
  output logic                     memReqByte,
  output logic [ADDR_W-1:0]        memReqAddr,
  output logic [(8<<OFF_BITS)-1:0] memReqWdata,
  input  logic                     memRspValid,
  input  logic [(8<<OFF_BITS)-1:0] memRspData,
  output logic [CNT_W-1:0]         hitCount,
  output logic [CNT_W-1:0]         missCount
);
  ctlStrobe_t stb;
  logic hitAny, vicNeedsWb, reqIsWrite;

  cache_control #(.WRITE_BACK(WRITE_BACK)) u_ctl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .hitAny(hitAny),
    .vicNeedsWb(vicNeedsWb), .reqIsWrite(reqIsWrite), .memRspValid(memRspValid),
    .stb(stb), .reqReady(reqReady), .rspValid(rspValid), .rspHit(rspHit),
    .memReqValid(memReqValid), .memReqWrite(memReqWrite), .memReqByte(memReqByte)
  );

  cache_datapath #(
    .ADDR_W(ADDR_W), .SET_BITS(SET_BITS), .WAYS(WAYS), .OFF_BITS(OFF_BITS),
    .WRITE_BACK(WRITE_BACK), .CNT_W(CNT_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .reqAddr(reqAddr), .reqWrite(reqWrite),
    .reqWdata(reqWdata), .memRspData(memRspData), .hitAny(hitAny),
    .vicNeedsWb(vicNeedsWb), .reqIsWrite(reqIsWrite), .rdData(rspRdata),
    .memAddr(memReqAddr), .memWdata(memReqWdata), .hitCount(hitCount),
    .missCount(missCount)
  );

endmodule

// File: tb/sa_data_cache_bench.sv
module sa_data_cache_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int totalChecks = 0;
  int badChecks = 0;

  // instance A: 2 sets, 2 ways, write-back
  logic vA = 0, wA = 0;
  logic [3:0] aA = 0;
  logic [7:0] dA = 0;
  logic readyA, rspA, hitA, mvA, mwA, mbA, mrA;
  logic [7:0] rdA;
  logic [3:0] maA;
  logic [15:0] mwdA, mrdA;
  logic [7:0] hcA, mcA;
  logic [7:0] memA [16];
  logic [7:0] goldA [16];

  // instance B: 4 sets, direct mapped, write-through
  logic vB = 0, wB = 0;
  logic [3:0] aB = 0;
  logic [7:0] dB = 0;
  logic readyB, rspB, hitB, mvB, mwB, mbB, mrB;
  logic [7:0] rdB;
  logic [3:0] maB;
  logic [15:0] mwdB, mrdB;
  logic [7:0] hcB, mcB;
  logic [7:0] memB [16];
  logic [7:0] goldB [16];

  sa_data_cache #(.ADDR_W(4), .SET_BITS(1), .WAYS(2), .OFF_BITS(1), .WRITE_BACK(1'b1), .CNT_W(8))
  u_sa_data_cache (
    .clk(clk), .rstN(rstN), .reqValid(vA), .reqWrite(wA), .reqAddr(aA), .reqWdata(dA),
    .reqReady(readyA), .rspValid(rspA), .rspHit(hitA), .rspRdata(rdA),
    .memReqValid(mvA), .memReqWrite(mwA), .memReqByte(mbA), .memReqAddr(maA),
    .memReqWdata(mwdA), .memRspValid(mrA), .memRspData(mrdA),
    .hitCount(hcA), .missCount(mcA));

  sa_data_cache #(.ADDR_W(4), .SET_BITS(2), .WAYS(1), .OFF_BITS(1), .WRITE_BACK(1'b0), .CNT_W(8))
  u_sa_data_cache_dm (
    .clk(clk), .rstN(rstN), .reqValid(vB), .reqWrite(wB), .reqAddr(aB), .reqWdata(dB),
    .reqReady(readyB), .rspValid(rspB), .rspHit(hitB), .rspRdata(rdB),
    .memReqValid(mvB), .memReqWrite(mwB), .memReqByte(mbB), .memReqAddr(maB),
    .memReqWdata(mwdB), .memRspValid(mrB), .memRspData(mrdB),
    .hitCount(hcB), .missCount(mcB));

  function automatic logic [7:0] pat(int i);
    return 8'(i * 17 + 3);
  endfunction

  // behavioural memories, two-cycle response
  logic busyA, busyB;
  logic [1:0] cntA, cntB;
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < 16; i++) memA[i] <= pat(i);
      busyA <= 0; cntA <= 0; mrA <= 0; mrdA <= 0;
    end else begin
      mrA <= 0;
      if (busyA) begin
        if (cntA == 0) begin mrA <= 1; busyA <= 0; end
        else cntA <= cntA - 1;
      end
      if (mvA) begin
        if (mwA && mbA) memA[maA] <= mwdA[7:0];
        else if (mwA) begin memA[{maA[3:1], 1'b0}] <= mwdA[7:0]; memA[{maA[3:1], 1'b1}] <= mwdA[15:8]; end
        else mrdA <= {memA[{maA[3:1], 1'b1}], memA[{maA[3:1], 1'b0}]};
        busyA <= 1; cntA <= 1;
      end
    end
  end

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < 16; i++) memB[i] <= pat(i);
      busyB <= 0; cntB <= 0; mrB <= 0; mrdB <= 0;
    end else begin
      mrB <= 0;
      if (busyB) begin
        if (cntB == 0) begin mrB <= 1; busyB <= 0; end
        else cntB <= cntB - 1;
      end
      if (mvB) begin
        if (mwB && mbB) memB[maB] <= mwdB[7:0];
        else if (mwB) begin memB[{maB[3:1], 1'b0}] <= mwdB[7:0]; memB[{maB[3:1], 1'b1}] <= mwdB[15:8]; end
        else mrdB <= {memB[{maB[3:1], 1'b1}], memB[{maB[3:1], 1'b0}]};
        busyB <= 1; cntB <= 1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    totalChecks++;
    if (!ok) begin
      badChecks++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic access(input bit dm, input bit wr, input logic [3:0] a, input logic [7:0] d,
                        output bit hitO, output logic [7:0] rdO, output bit busyOk);
    bit got;
    @(negedge clk);
    if (dm) begin vB = 1; wB = wr; aB = a; dB = d; end
    else begin vA = 1; wA = wr; aA = a; dA = d; end
    @(negedge clk);
    vA = 0; vB = 0;
    busyOk = 1; got = 0; hitO = 0; rdO = 0;
    for (int c = 0; c < 50 && !got; c++) begin
      if (dm ? rspB : rspA) begin
        got = 1;
        hitO = dm ? hitB : hitA;
        rdO = dm ? rdB : rdA;
      end else begin
        if (dm ? readyB : readyA) busyOk = 0;
        @(negedge clk);
      end
    end
    check(got, "R12 response", int'(got), 1);
    if (wr) begin
      if (dm) goldB[a] = d; else goldA[a] = d;
    end
  endtask

  // one access with its expected outcome
  task automatic step(input bit dm, input bit wr, input logic [3:0] a, input logic [7:0] d,
                      input bit expHit, input string req);
    bit h, b;
    logic [7:0] r;
    access(dm, wr, a, d, h, r, b);
    check(h == expHit, req, int'(h), int'(expHit));
    if (!wr) check(r == (dm ? goldB[a] : goldA[a]), {req, " R2 data"}, int'(r), int'(dm ? goldB[a] : goldA[a]));
  endtask

  task automatic test_reset();
    // R11
    check(readyA && readyB, "R11 ready", int'(readyA), 1);
    check(!rspA && !rspB, "R11 rspValid", int'(rspA), 0);
    check(hcA == 0 && mcA == 0 && hcB == 0 && mcB == 0, "R11 counters", int'(hcA + mcA + hcB + mcB), 0);
  endtask

  task automatic test_dm_trace();
    // R1 R3: tag 1 bit, set bits 2:1, offset bit 0
    step(1, 0, 4'd0, 8'h0, 0, "R3 rd0");
    step(1, 0, 4'd1, 8'h0, 1, "R3 rd1");
    step(1, 0, 4'd7, 8'h0, 0, "R3 rd7");
    step(1, 0, 4'd8, 8'h0, 0, "R3 rd8");
    step(1, 0, 4'd0, 8'h0, 0, "R3 rd0 again");
  endtask

  task automatic test_sa_trace();
    // R1 R4 R5: tag bits 3:2, set bit 1, offset bit 0
    step(0, 0, 4'd0, 8'h0, 0, "R4 rd0");
    step(0, 0, 4'd1, 8'h0, 1, "R4 rd1");
    step(0, 0, 4'd7, 8'h0, 0, "R4 rd7");
    step(0, 0, 4'd8, 8'h0, 0, "R5 rd8 fills free way");
    step(0, 0, 4'd0, 8'h0, 1, "R4 rd0 again");
  endtask

  task automatic test_write_back();
    bit h, b;
    logic [7:0] r;
    step(0, 1, 4'd9, 8'hA5, 1, "R6 write hit");
    @(negedge clk);
    check(memA[9] == pat(9), "R6 no early write", int'(memA[9]), int'(pat(9)));
    step(0, 0, 4'd4, 8'h0, 0, "R5 evict LRU block0");
    check(memA[9] == pat(9), "R6 clean eviction", int'(memA[9]), int'(pat(9)));
    access(0, 0, 4'd12, 8'h0, h, r, b);
    check(!h, "R5 rd12 miss", int'(h), 0);
    check(b, "R12 busy through writeback", int'(b), 1);
    check(memA[9] == 8'hA5, "R6 dirty writeback", int'(memA[9]), 'hA5);
    step(0, 0, 4'd4, 8'h0, 1, "R5 recent block kept");
    step(0, 0, 4'd9, 8'h0, 0, "R6 reread after evict");
    step(0, 1, 4'd2, 8'h3C, 0, "R7 write miss");
    @(negedge clk);
    check(memA[2] == pat(2), "R7 memory untouched", int'(memA[2]), int'(pat(2)));
    step(0, 0, 4'd2, 8'h0, 1, "R7 allocated");
    @(negedge clk);
    check(hcA == 8'd5, "R10 hits A", int'(hcA), 5);
    check(mcA == 8'd7, "R10 misses A", int'(mcA), 7);
  endtask

  task automatic test_write_through();
    step(1, 1, 4'd1, 8'h77, 1, "R8 write hit");
    check(memB[1] == 8'h77, "R8 immediate write", int'(memB[1]), 'h77);
    step(1, 1, 4'd5, 8'h55, 0, "R9 write miss");
    check(memB[5] == 8'h55, "R9 memory written", int'(memB[5]), 'h55);
    step(1, 0, 4'd5, 8'h0, 0, "R9 no allocate");
    step(1, 0, 4'd1, 8'h0, 1, "R8 cached copy");
    @(negedge clk);
    check(hcB == 8'd3, "R10 hits B", int'(hcB), 3);
    check(mcB == 8'd6, "R10 misses B", int'(mcB), 6);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin goldA[i] = pat(i); goldB[i] = pat(i); end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    test_reset();
    test_dm_trace();
    test_sa_trace();
    test_write_back();
    test_write_through();
    $display("test done: total=%0d bad=%0d", totalChecks, badChecks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    totalChecks++;
    badChecks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", totalChecks, badChecks);
    $finish;
  end

endmodule